// File: doc/BRIEF.md
# PLL Setting Search Engine

This block works out the control word for a programmable PLL whose output is `parent × (mul + 1) / ((div1 + 1) × 2^div2)`. The caller gives it a parent rate and a requested rate, both as integers in hertz, and pulses `start`. The engine then tries candidate settings one per cycle. It keeps only candidates whose output does not exceed the request. On completion it returns the packed control word, the rate that setting produces, and a warning flag.

The search stops as soon as a setting hits the request exactly. If no setting is exact, the search covers the whole space and returns the closest setting below the request. The engine also chooses a loop-filter range code from the reference frequency seen after the predivider. To do that it first converts the parent rate to whole megahertz with an internal shift-subtract divider. The PLL itself and any register access sit outside this block.

Top module: `pll_setting_search`

## Requirements
- R1: The rate for a setting is floor(parent × (mul + 1) / 2^(div1 + div2)), with mul in 0..255, div1 in 0..1 and div2 in 0..7. The control word carries the filter code in bits 26:24, mul in bits 23:16, div1 in bit 8 and div2 in bits 2:0. Every other bit is zero.
- R2: Candidates are visited with div1 as the outer loop (1 then 0), div2 as the middle loop (7 down to 0) and mul as the inner loop (0 up to 255). The first candidate whose rate equals the request ends the search and is returned.
- R3: The returned rate never exceeds the request. When there is no exact hit, the candidate with the strictly smallest error (request minus rate) is returned, so on a tie the one visited first is kept.
- R4: The filter code is derived from f = floor(parent / 1,000,000) / (div1 + 1), using the chosen div1. The code is 7 for f ≥ 166, 6 for f ≥ 104, 5 for f ≥ 65, 4 for f ≥ 42, 3 for f ≥ 26, 2 for f ≥ 16, 1 for f ≥ 10, and 0 below 10.
- R5: `warn` is set with the result when f lies outside 10..200 or when the returned rate is not an exact hit. Otherwise it is clear.
- R6: When every candidate exceeds the request, the control word and the rate are zero and `warn` is set.
- R7: `start` is taken only while `busy` is low. A `start` pulse during a search has no effect on that search's result.
- R8: `done` is high for exactly one cycle per search. The control word, rate and `warn` stay unchanged until the next accepted `start` completes, even if the inputs change.
- R9: After reset, `busy`, `done`, `warn`, the control word and the rate are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search with the current rates |
| parent_rate | input | 32 | Reference rate in Hz |
| req_rate | input | 32 | Requested output rate in Hz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| ctrl_word | output | 32 | Packed PLL control word |
| achieved_rate | output | 32 | Rate produced by the returned setting |
| warn | output | 1 | Inexact result or reference outside range |

## Verification
A search accepted on one edge spends 32 cycles in the megahertz division and then tries one candidate per cycle, up to 4096 of them. One more cycle registers the result together with `done`. An exact hit on candidate k therefore finishes after about 34 + k cycles, and a full scan after about 4130. Because of this spread, the bench does not predict a fixed cycle. It polls `done` on falling edges and reads all three results on the falling edge where `done` is high. The one-cycle pulse and the holding of the results are checked on the falling edges that follow.

// File: rtl/pllsrch_pkg.sv
package pllsrch_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MHZ  = 2'd1,
      ST_SCAN = 2'd2,
      ST_FIN  = 2'd3
   } srch_state_t;

   localparam int FILT_W = 3;
   localparam int FILT_N = 7;

   // lower edge in MHz of filter code i+1
   function automatic int filt_edge(input int i);
      case (i)
         0:       return 10;
         1:       return 16;
         2:       return 26;
         3:       return 42;
         4:       return 65;
         5:       return 104;
         default: return 166;
      endcase
   endfunction

endpackage

// File: rtl/pllsrch_div.sv
module pllsrch_div #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic [W-1:0] quo,
   output logic         fin
);
   localparam int CW = $clog2(W + 1);
   localparam int W2 = 2 * W;

   logic [W-1:0]  rem, q, num_q, den_q;
   logic [CW-1:0] cnt;
   logic          run;
   logic [W:0]    rem_sh;
   logic          ge;

   always_comb begin
      rem_sh = {rem, q[W-1]};
      ge     = rem_sh >= {1'b0, den_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem   <= '0;
         q     <= '0;
         num_q <= '0;
         den_q <= '0;
         cnt   <= '0;
         run   <= 1'b0;
         fin   <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            rem   <= '0;
            q     <= num;
            num_q <= num;
            den_q <= den;
            cnt   <= CW'(W);
            run   <= 1'b1;
         end else if (run) begin
            rem <= ge ? W'(rem_sh - {1'b0, den_q}) : rem_sh[W-1:0];
            q   <= {q[W-2:0], ge};
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
               run <= 1'b0;
               fin <= 1'b1;
            end
         end
      end
   end

   assign quo = q;

   // quotient and remainder rebuild the dividend (supports R4)
   assert_div_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> (W2'(quo) * W2'(den_q) + W2'(rem)) == W2'(num_q));
   assert_div_rem_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> rem < den_q);

endmodule

// File: rtl/pllsrch_filt.sv
module pllsrch_filt #(
   parameter int W      = 32,
   parameter int LO_MHZ = 10,
   parameter int HI_MHZ = 200
) (
   input  logic [W-1:0]                     mhz,
   output logic [pllsrch_pkg::FILT_W-1:0]   code,
   output logic                             out_rng
);
   import pllsrch_pkg::*;

   logic [FILT_N-1:0] above;

   for (genvar i = 0; i < FILT_N; i++) begin : g_edge
      assign above[i] = mhz >= W'(filt_edge(i));
   end

   always_comb begin
      code = '0;
      for (int i = 0; i < FILT_N; i++)
         code = code + FILT_W'(above[i]);
   end

   assign out_rng = (mhz < W'(LO_MHZ)) || (mhz > W'(HI_MHZ));

endmodule

// File: rtl/pllsrch_cand.sv
module pllsrch_cand #(
   parameter int W     = 32,
   parameter int MUL_W = 8,
   parameter int D2_W  = 3
) (
   input  logic [W-1:0]     parent,
   input  logic [W-1:0]     req,
   input  logic [MUL_W-1:0] mul,
   input  logic             d1,
   input  logic [D2_W-1:0]  d2,
   output logic             fits,
   output logic             exact,
   output logic [W-1:0]     rate,
   output logic [W-1:0]     err
);
   localparam int PW = W + MUL_W + 1;
   localparam int SW = D2_W + 1;

   logic [PW-1:0] prod, tclk;
   logic [SW-1:0] sh;

   always_comb begin
      prod  = PW'(parent) * PW'({1'b0, mul} + 1'b1);
      sh    = {1'b0, d2} + SW'(d1);
      tclk  = prod >> sh;
      fits  = tclk <= PW'(req);
      rate  = tclk[W-1:0];
      err   = req - rate;
      exact = fits && (err == '0);
   end

endmodule

// File: rtl/pll_setting_search.sv
module pll_setting_search #(
   parameter int RATE_W     = 32,
   parameter int MUL_W      = 8,
   parameter int D2_W       = 3,
   parameter int HZ_PER_MHZ = 1000000,
   parameter int LO_MHZ     = 10,
   parameter int HI_MHZ     = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [RATE_W-1:0] parent_rate,
   input  logic [RATE_W-1:0] req_rate,
   output logic              busy,
   output logic              done,
   output logic [31:0]       ctrl_word,
   output logic [RATE_W-1:0] achieved_rate,
   output logic              warn
);
   import pllsrch_pkg::*;

   localparam int MUL_MAX = (1 << MUL_W) - 1;
   localparam int D2_MAX  = (1 << D2_W) - 1;

   if (MUL_W > 8) begin : g_bad_mul
      $error("MUL_W must fit the 8-bit multiplier field");
   end
   if (D2_W > 3) begin : g_bad_d2
      $error("D2_W must fit the 3-bit post-divider field");
   end
   if (RATE_W < 24 || RATE_W > 32) begin : g_bad_rate
      $error("RATE_W must lie in 24..32");
   end

   srch_state_t       st;
   logic [RATE_W-1:0] par_q, req_q, mhz_q;
   logic [MUL_W-1:0]  c_mul, b_mul;
   logic              c_d1, b_d1;
   logic [D2_W-1:0]   c_d2, b_d2;
   logic [RATE_W-1:0] b_err, b_rate;
   logic              found, hit;

   logic              div_go, div_fin;
   logic [RATE_W-1:0] div_quo;
   logic              cd_fits, cd_exact;
   logic [RATE_W-1:0] cd_rate, cd_err;
   logic [FILT_W-1:0] f_code;
   logic              f_out;
   logic              last;
   logic [31:0]       pack;

   assign div_go = (st == ST_IDLE) && start;

   pllsrch_div #(.W(RATE_W)) u_div (
      .clk(clk), .rst_n(rst_n), .go(div_go), .num(parent_rate),
      .den(RATE_W'(HZ_PER_MHZ)), .quo(div_quo), .fin(div_fin)
   );

   pllsrch_cand #(.W(RATE_W), .MUL_W(MUL_W), .D2_W(D2_W)) u_cand (
      .parent(par_q), .req(req_q), .mul(c_mul), .d1(c_d1), .d2(c_d2),
      .fits(cd_fits), .exact(cd_exact), .rate(cd_rate), .err(cd_err)
   );

   pllsrch_filt #(.W(RATE_W), .LO_MHZ(LO_MHZ), .HI_MHZ(HI_MHZ)) u_filt (
      .mhz(mhz_q >> b_d1), .code(f_code), .out_rng(f_out)
   );

   assign last = !c_d1 && (c_d2 == '0) && (c_mul == MUL_W'(MUL_MAX));

   always_comb begin
      pack              = '0;
      pack[26:24]       = f_code;
      pack[16 +: MUL_W] = b_mul;
      pack[8]           = b_d1;
      pack[0 +: D2_W]   = b_d2;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st            <= ST_IDLE;
         par_q         <= '0;
         req_q         <= '0;
         mhz_q         <= '0;
         c_mul         <= '0;
         c_d1          <= 1'b0;
         c_d2          <= '0;
         b_mul         <= '0;
         b_d1          <= 1'b0;
         b_d2          <= '0;
         b_err         <= '0;
         b_rate        <= '0;
         found         <= 1'b0;
         hit           <= 1'b0;
         done          <= 1'b0;
         ctrl_word     <= '0;
         achieved_rate <= '0;
         warn          <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: if (start) begin
               par_q <= parent_rate;
               req_q <= req_rate;
               c_mul <= '0;
               c_d1  <= 1'b1;
               c_d2  <= D2_W'(D2_MAX);
               found <= 1'b0;
               hit   <= 1'b0;
               st    <= ST_MHZ;
            end
            ST_MHZ: if (div_fin) begin
               mhz_q <= div_quo;
               st    <= ST_SCAN;
            end
            ST_SCAN: begin
               if (cd_fits && (!found || cd_err < b_err)) begin
                  found  <= 1'b1;
                  b_err  <= cd_err;
                  b_rate <= cd_rate;
                  b_mul  <= c_mul;
                  b_d1   <= c_d1;
                  b_d2   <= c_d2;
               end
               if (cd_exact) begin
                  hit <= 1'b1;
                  st  <= ST_FIN;
               end else if (last) begin
                  st <= ST_FIN;
               end else if (c_mul == MUL_W'(MUL_MAX)) begin
                  c_mul <= '0;
                  if (c_d2 == '0) begin
                     c_d2 <= D2_W'(D2_MAX);
                     c_d1 <= 1'b0;
                  end else begin
                     c_d2 <= c_d2 - 1'b1;
                  end
               end else begin
                  c_mul <= c_mul + 1'b1;
               end
            end
            default: begin
               if (found) begin
                  ctrl_word     <= pack;
                  achieved_rate <= b_rate;
                  warn          <= !hit || f_out;
               end else begin
                  ctrl_word     <= '0;
                  achieved_rate <= '0;
                  warn          <= 1'b1;
               end
               done <= 1'b1;
               st   <= ST_IDLE;
            end
         endcase
      end
   end

   assign busy = (st != ST_IDLE);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_no_overshoot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> achieved_rate <= req_q);
   assert_err_shrinks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SCAN && found) |=> b_err <= $past(b_err));
   assert_busy_from_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
   assert_empty_warns_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ctrl_word == '0) |-> warn);
   assert_quiet_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !warn) |-> achieved_rate == req_q);

endmodule

// File: tb/sim_pll_setting_search.sv
module sim_pll_setting_search;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] parent_rate = '0;
   logic [31:0] req_rate = '0;
   logic        busy, done, warn;
   logic [31:0] ctrl_word, achieved_rate;

   int tests = 0;
   int fails = 0;
   bit ended = 1'b0;

   always #10 clk = ~clk;

   pll_setting_search u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .parent_rate(parent_rate), .req_rate(req_rate),
      .busy(busy), .done(done), .ctrl_word(ctrl_word),
      .achieved_rate(achieved_rate), .warn(warn)
   );

   // {parent, request, expected word, expected rate, expected warn}
   localparam int NV = 13;
   localparam logic [128:0] VECS [NV] = '{
      {32'd24000000,  32'd1500000,    32'h010F0107, 32'd1500000,    1'b0}, // R2 first exact, mul 15
      {32'd24000000,  32'd600000000,  32'h01C70102, 32'd600000000,  1'b0}, // R2 div2 order
      {32'd20000000,  32'd4000000000, 32'h02C70000, 32'd4000000000, 1'b0}, // R1 div1 0, code 2
      {32'd400000000, 32'd15625000,   32'h07090107, 32'd15625000,   1'b0}, // R4 f=200
      {32'd500000000, 32'd1953125,    32'h07000107, 32'd1953125,    1'b1}, // R5 f=250
      {32'd24000000,  32'd1000,       32'h00000000, 32'd0,          1'b1}, // R6 nothing fits
      {32'd24000000,  32'd93751,      32'h01000107, 32'd93750,      1'b1}, // R3 inexact
      {32'd24000000,  32'd187501,     32'h01010107, 32'd187500,     1'b1}, // R3 tie keeps first
      {32'd330000000, 32'd2578125,    32'h06010107, 32'd2578125,    1'b0}, // R4 f=165
      {32'd332000000, 32'd2593750,    32'h07010107, 32'd2593750,    1'b0}, // R4 f=166
      {32'd18000000,  32'd140625,     32'h00010107, 32'd140625,     1'b1}, // R4 f=9
      {32'd20000000,  32'd156250,     32'h01010107, 32'd156250,     1'b0}, // R4 f=10
      {32'd402000000, 32'd3140625,    32'h07010107, 32'd3140625,    1'b1}  // R5 f=201
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic launch(input logic [31:0] p, input logic [31:0] r);
      @(negedge clk);
      parent_rate = p;
      req_rate    = r;
      start       = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      for (int n = 0; n < 6000 && !done; n++) @(negedge clk);
   endtask

   initial begin : wdog
      repeat (150000) @(posedge clk);
      if (!ended) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] held_w, held_r;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 busy", {31'b0, busy}, 32'd0);
      chk("R9 done", {31'b0, done}, 32'd0);
      chk("R9 warn", {31'b0, warn}, 32'd0);
      chk("R9 word", ctrl_word, 32'd0);
      chk("R9 rate", achieved_rate, 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         launch(VECS[i][128:97], VECS[i][96:65]);
         wait_done();
         chk($sformatf("R8 done seen v%0d", i), {31'b0, done}, 32'd1);
         chk($sformatf("R1 word v%0d", i), ctrl_word, VECS[i][64:33]);
         chk($sformatf("R3 rate v%0d", i), achieved_rate, VECS[i][32:1]);
         chk($sformatf("R5 warn v%0d", i), {31'b0, warn}, {31'b0, VECS[i][0]});
      end

      // R7: start pulses during a search are ignored
      launch(32'd24000000, 32'd93751);
      chk("R7 busy", {31'b0, busy}, 32'd1);
      repeat (10) @(negedge clk);
      parent_rate = 32'd332000000;
      req_rate    = 32'd2593750;
      start       = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      chk("R7 word", ctrl_word, 32'h01000107);
      chk("R7 rate", achieved_rate, 32'd93750);

      // R8: single-cycle pulse, results held while inputs move
      held_w = ctrl_word;
      held_r = achieved_rate;
      @(negedge clk);
      chk("R8 pulse end", {31'b0, done}, 32'd0);
      chk("R8 idle", {31'b0, busy}, 32'd0);
      parent_rate = 32'd500000000;
      req_rate    = 32'd1;
      repeat (6) @(negedge clk);
      chk("R8 word held", ctrl_word, held_w);
      chk("R8 rate held", achieved_rate, held_r);
      chk("R8 warn held", {31'b0, warn}, 32'd1);

      ended = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule